// File: doc/BRIEF.md
# FM-Mode Digital PLL Clock Recovery

This block recovers bit timing from a serial input coded as FM0, FM1 or Manchester. All of these codes have at least one transition in every bit cell. The block runs from an oversampling clock at 32 times the bit rate. A five-bit phase counter steps through one 0..31 cycle per bit cell. The receive input is synchronised, and its transitions are detected. Only a transition that falls in an acceptance window around count 16 is treated as the expected clock transition. When that transition arrives in the later half of the window, the next cycle is lengthened by holding count 5 for a second clock. When it arrives in the earlier half, the next cycle is shortened by skipping count 5. All other transitions, such as data transitions in mid-cell, are ignored.

The counter drives two clock outputs, one for the receiver and one for a transmitter. A window with no transition raises a sticky flag. A second consecutive empty window raises a second sticky flag and sends the block back to search mode. The block enters search mode only at count 2, when both clock outputs are low. In search mode the counter parks at count 16 and both outputs stay low. The first input transition after that restarts tracking. Dropping enable, or issuing the search command, forces search mode at once and clears both flags.

Top module: `fm_dpll_clkrec`

## Requirements
- R1: After reset, in_search is 1, rx_clk and tx_clk are 0, and miss_one and miss_two are 0.
- R2: While in search mode the phase counter stays at count 16, and rx_clk and tx_clk stay 0 until a transition is detected.
- R3: In search mode with en high, a change on rxd that is first sampled at clock edge k is detected at edge k+2 as if it were at count 16. in_search falls and rx_clk rises after edge k+2, and counting continues from count 17.
- R4: While tracking, a cycle with no correction lasts 32 clocks. rx_clk is 1 exactly for counts 17..31, and tx_clk is 1 exactly for counts 3..15.
- R5: A transition detected while the counter is in counts 19..31 or 0..11 has no effect on the timing.
- R6: A transition detected first in a cycle at counts 16..18 makes the next cycle hold count 5 for two clocks, giving a 33-clock cycle.
- R7: A transition detected first in a cycle at counts 12..15 makes the next cycle skip count 5, giving a 31-clock cycle.
- R8: Only the first transition detected in counts 12..18 of a cycle is used. Later ones in the same window are ignored.
- R9: A cycle with no transition detected in counts 12..18 sets miss_one, which then stays set. The following cycle is not corrected.
- R10: Two consecutive cycles with no transition in the window set miss_two. At the next count 2, with both clock outputs low, the block enters search mode.
- R11: A one-cycle clr_miss_cmd clears miss_one and miss_two on the next clock edge. A flag being set on that same edge wins over the clear.
- R12: With en low, or with search_cmd high, the next clock edge puts the block in search mode at count 16 and clears both flags, whatever rxd does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, 32 per bit cell |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low holds the block in search mode |
| search_cmd | input | 1 | One-cycle command to enter search mode |
| clr_miss_cmd | input | 1 | One-cycle command to clear the missing-clock flags |
| rxd | input | 1 | Asynchronous coded serial input |
| rx_clk | output | 1 | Recovered receive clock |
| tx_clk | output | 1 | Recovered transmit clock |
| miss_one | output | 1 | Sticky flag: one window without a transition |
| miss_two | output | 1 | Sticky flag: two consecutive windows without a transition |
| in_search | output | 1 | High while in search mode |

## Verification
The assertions assume that the commands are synchronous to clk and that reset is held from time zero, so the first cycles they look back on are reset cycles. They also assume the cell length is a power of two, so that the counter wraps naturally. The stimulus changes rxd and the commands only just after a rising edge, so every change is seen whole by the synchroniser one edge later. The sweeps cover bit-cell periods of 30 to 34 clocks, every starting phase from 0 to 7, and coding with and without mid-cell data transitions. This exercises the stretch, skip, miss and search paths, and the bench predicts each output cycle by cycle from the stated counts.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

    typedef enum logic [1:0] {
        ADJ_NONE    = 2'd0,
        ADJ_STRETCH = 2'd1,
        ADJ_SKIP    = 2'd2
    } adj_e;

    typedef struct packed {
        logic one_missing;
        logic two_missing;
    } miss_t;

    typedef struct packed {
        logic force_search;
        logic clr_miss;
        logic edge_seen;
    } ctl_t;

    function automatic logic in_span(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/dpll_edge_sync.sv
module dpll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic edge_seen
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-1:0], din};
    end

    assign edge_seen = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/dpll_cycle_ctr.sv
module dpll_cycle_ctr
    import dpll_pkg::*;
#(
    parameter int CELL   = 32,
    parameter int ADJ    = 5,
    parameter int DECIDE = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    force_search,
    input  logic                    edge_seen,
    input  adj_e                    adj,
    input  logic                    go_search,
    output logic [$clog2(CELL)-1:0] cnt,
    output logic [$clog2(CELL)-1:0] cnt_nxt,
    output logic                    searching,
    output logic                    search_nxt,
    output logic                    adj_taken
);
    localparam int CW   = $clog2(CELL);
    localparam int PARK = CELL / 2;

    always_comb begin
        cnt_nxt    = cnt;
        search_nxt = searching;
        adj_taken  = 1'b0;
        if (force_search) begin
            cnt_nxt    = CW'(PARK);
            search_nxt = 1'b1;
        end else if (searching) begin
            if (edge_seen) begin
                cnt_nxt    = CW'(PARK + 1);
                search_nxt = 1'b0;
            end
        end else if (go_search && cnt == CW'(DECIDE)) begin
            cnt_nxt    = CW'(PARK);
            search_nxt = 1'b1;
        end else if (adj == ADJ_SKIP && cnt == CW'(ADJ - 1)) begin
            cnt_nxt   = CW'(ADJ + 1);
            adj_taken = 1'b1;
        end else if (adj == ADJ_STRETCH && cnt == CW'(ADJ)) begin
            cnt_nxt   = cnt;
            adj_taken = 1'b1;
        end else begin
            cnt_nxt = (cnt == CW'(CELL - 1)) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= CW'(PARK);
            searching <= 1'b1;
        end else begin
            cnt       <= cnt_nxt;
            searching <= search_nxt;
        end
    end
endmodule

// File: rtl/dpll_phase_track.sv
module dpll_phase_track
    import dpll_pkg::*;
#(
    parameter int CELL = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ctl_t                    ctl,
    input  logic [$clog2(CELL)-1:0] cnt,
    input  logic                    searching,
    input  logic                    adj_taken,
    output adj_e                    adj,
    output logic                    go_search,
    output miss_t                   miss
);
    localparam int HALF   = CELL / 2;
    localparam int WIN_LO = HALF - HALF / 4;
    localparam int WIN_HI = HALF + HALF / 8;

    logic hit_q, prev_miss_q;
    logic in_win, take, at_close, missed, double_miss;

    always_comb begin
        in_win      = !searching && in_span(int'(cnt), WIN_LO, WIN_HI);
        take        = ctl.edge_seen && in_win && !hit_q;
        at_close    = !searching && (int'(cnt) == WIN_HI);
        missed      = at_close && !(hit_q || take);
        double_miss = missed && prev_miss_q;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.force_search) begin
            hit_q       <= 1'b0;
            prev_miss_q <= 1'b0;
            adj         <= ADJ_NONE;
            go_search   <= 1'b0;
            miss        <= '0;
        end else if (searching) begin
            go_search <= 1'b0;
            if (ctl.edge_seen) begin
                hit_q       <= 1'b1;
                prev_miss_q <= 1'b0;
                adj         <= ADJ_NONE;
            end
            miss.one_missing <= miss.one_missing && !ctl.clr_miss;
            miss.two_missing <= miss.two_missing && !ctl.clr_miss;
        end else begin
            if (take) begin
                hit_q <= 1'b1;
                adj   <= (int'(cnt) >= HALF) ? ADJ_STRETCH : ADJ_SKIP;
            end else if (adj_taken) begin
                adj <= ADJ_NONE;
            end
            if (at_close) begin
                hit_q       <= 1'b0;
                prev_miss_q <= missed;
                if (double_miss) go_search <= 1'b1;
            end
            miss.one_missing <= (miss.one_missing && !ctl.clr_miss) || missed;
            miss.two_missing <= (miss.two_missing && !ctl.clr_miss) || double_miss;
        end
    end
endmodule

// File: rtl/dpll_clk_out.sv
module dpll_clk_out #(
    parameter int CELL   = 32,
    parameter int DECIDE = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(CELL)-1:0] cnt_nxt,
    input  logic                    search_nxt,
    output logic                    rx_clk,
    output logic                    tx_clk
);
    import dpll_pkg::*;
    localparam int HALF = CELL / 2;
    localparam int RX_LO = HALF + 1;
    localparam int RX_HI = CELL - 1;
    localparam int TX_LO = DECIDE + 1;
    localparam int TX_HI = HALF - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_clk <= 1'b0;
            tx_clk <= 1'b0;
        end else begin
            rx_clk <= !search_nxt && in_span(int'(cnt_nxt), RX_LO, RX_HI);
            tx_clk <= !search_nxt && in_span(int'(cnt_nxt), TX_LO, TX_HI);
        end
    end
endmodule

// File: rtl/fm_dpll_clkrec.sv
module fm_dpll_clkrec
    import dpll_pkg::*;
#(
    parameter int CELL        = 32,
    parameter int ADJ_POS     = 5,
    parameter int DECIDE_POS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic search_cmd,
    input  logic clr_miss_cmd,
    input  logic rxd,
    output logic rx_clk,
    output logic tx_clk,
    output logic miss_one,
    output logic miss_two,
    output logic in_search
);
    localparam int CW = $clog2(CELL);

    logic          edge_seen;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          search_nxt, adj_taken, go_search;
    adj_e          adj;
    miss_t         miss;
    ctl_t          ctl;

    assign ctl.force_search = !en || search_cmd;
    assign ctl.clr_miss     = clr_miss_cmd;
    assign ctl.edge_seen    = edge_seen;

    dpll_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(rxd), .edge_seen(edge_seen)
    );

    dpll_cycle_ctr #(.CELL(CELL), .ADJ(ADJ_POS), .DECIDE(DECIDE_POS)) u_ctr (
        .clk(clk), .rst(rst),
        .force_search(ctl.force_search), .edge_seen(edge_seen),
        .adj(adj), .go_search(go_search),
        .cnt(cnt_q), .cnt_nxt(cnt_nxt),
        .searching(in_search), .search_nxt(search_nxt),
        .adj_taken(adj_taken)
    );

    dpll_phase_track #(.CELL(CELL)) u_track (
        .clk(clk), .rst(rst), .ctl(ctl),
        .cnt(cnt_q), .searching(in_search), .adj_taken(adj_taken),
        .adj(adj), .go_search(go_search), .miss(miss)
    );

    dpll_clk_out #(.CELL(CELL), .DECIDE(DECIDE_POS)) u_out (
        .clk(clk), .rst(rst),
        .cnt_nxt(cnt_nxt), .search_nxt(search_nxt),
        .rx_clk(rx_clk), .tx_clk(tx_clk)
    );

    assign miss_one = miss.one_missing;
    assign miss_two = miss.two_missing;
endmodule

// File: rtl/fm_dpll_chk.sv
module fm_dpll_chk #(
    parameter int CELL       = 32,
    parameter int ADJ_POS    = 5,
    parameter int DECIDE_POS = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic                    search_cmd,
    input logic                    clr_miss_cmd,
    input logic                    rx_clk,
    input logic                    tx_clk,
    input logic                    miss_one,
    input logic                    miss_two,
    input logic                    in_search,
    input logic                    edge_seen,
    input logic [$clog2(CELL)-1:0] cnt
);
    localparam int PARK = CELL / 2;
    logic live;
    assign live = en && !search_cmd;

    // R2
    search_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        in_search |-> (!rx_clk && !tx_clk));

    // R2
    park_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (in_search && live && !edge_seen) |=> (in_search && int'(cnt) == PARK));

    // R3
    search_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (in_search && live && edge_seen) |=> (!in_search && int'(cnt) == PARK + 1));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_search && live && int'(cnt) != ADJ_POS - 1 && int'(cnt) != ADJ_POS
         && int'(cnt) != DECIDE_POS)
        |=> (int'(cnt) == (int'($past(cnt)) + 1) % CELL));

    // R6 and R7
    adjust_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_search && live && int'(cnt) == ADJ_POS - 1)
        |=> (int'(cnt) == ADJ_POS || int'(cnt) == ADJ_POS + 1));

    // R9
    one_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_one && live && !clr_miss_cmd) |=> miss_one);

    // R10
    two_implies_one_chk: assert property (@(posedge clk) disable iff (rst)
        miss_two |-> miss_one);

    // R10
    decide_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(in_search) && $past(live))
        |-> (int'($past(cnt)) == DECIDE_POS && $past(!rx_clk && !tx_clk)));

    // R12
    force_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !live |=> (in_search && !miss_one && !miss_two));
endmodule

bind fm_dpll_clkrec fm_dpll_chk #(
    .CELL(CELL), .ADJ_POS(ADJ_POS), .DECIDE_POS(DECIDE_POS)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .search_cmd(search_cmd),
    .clr_miss_cmd(clr_miss_cmd), .rx_clk(rx_clk), .tx_clk(tx_clk),
    .miss_one(miss_one), .miss_two(miss_two), .in_search(in_search),
    .edge_seen(edge_seen), .cnt(cnt_q)
);

// File: tb/fm_dpll_clkrec_tb.sv
module fm_dpll_clkrec_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst = 1'b1, en = 1'b0, search_cmd = 1'b0, clr_miss_cmd = 1'b0, rxd = 1'b0;
    logic rx_clk, tx_clk, miss_one, miss_two, in_search;

    fm_dpll_clkrec u_dut (
        .clk(clk), .rst(rst), .en(en), .search_cmd(search_cmd),
        .clr_miss_cmd(clr_miss_cmd), .rxd(rxd), .rx_clk(rx_clk), .tx_clk(tx_clk),
        .miss_one(miss_one), .miss_two(miss_two), .in_search(in_search)
    );

    int checks = 0, fails = 0;
    string cur_req = "R1";

    // expected-behaviour state, from the stated counts
    int m_s1, m_s2, m_s3, m_cnt, m_srch, m_hit, m_adj, m_prev, m_go, m_one, m_two;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        int e, take, close, missed, dbl, ncnt, nadj, nsrch;
        e = m_s2 ^ m_s3;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(rxd);
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
            m_cnt = 16; m_srch = 1; m_hit = 0; m_adj = 0; m_prev = 0;
            m_go = 0; m_one = 0; m_two = 0;
        end else if (!en || search_cmd) begin
            m_cnt = 16; m_srch = 1; m_hit = 0; m_adj = 0; m_prev = 0;
            m_go = 0; m_one = 0; m_two = 0;
        end else if (m_srch != 0) begin
            if (e != 0) begin
                m_srch = 0; m_cnt = 17; m_hit = 1; m_adj = 0; m_prev = 0;
            end
            m_go = 0;
            if (clr_miss_cmd) begin m_one = 0; m_two = 0; end
        end else begin
            take   = (e != 0 && m_cnt >= 12 && m_cnt <= 18 && m_hit == 0) ? 1 : 0;
            close  = (m_cnt == 18) ? 1 : 0;
            missed = (close != 0 && m_hit == 0 && take == 0) ? 1 : 0;
            dbl    = (missed != 0 && m_prev != 0) ? 1 : 0;
            nadj = m_adj; nsrch = 0;
            if (m_go != 0 && m_cnt == 2) begin ncnt = 16; nsrch = 1; end
            else if (m_adj == 2 && m_cnt == 4) begin ncnt = 6; nadj = 0; end
            else if (m_adj == 1 && m_cnt == 5) begin ncnt = 5; nadj = 0; end
            else ncnt = (m_cnt + 1) % 32;
            if (take != 0) begin m_hit = 1; nadj = (m_cnt >= 16) ? 1 : 2; end
            if (close != 0) begin
                m_hit = 0; m_prev = missed;
                if (dbl != 0) m_go = 1;
            end
            m_one = ((m_one != 0 && !clr_miss_cmd) || missed != 0) ? 1 : 0;
            m_two = ((m_two != 0 && !clr_miss_cmd) || dbl != 0) ? 1 : 0;
            m_cnt = ncnt; m_adj = nadj; m_srch = nsrch;
        end
    endtask

    task automatic step();
        int erx, etx;
        @(posedge clk);
        model_step();
        #1;
        erx = (m_srch == 0 && m_cnt >= 17) ? 1 : 0;
        etx = (m_srch == 0 && m_cnt >= 3 && m_cnt <= 15) ? 1 : 0;
        chk(cur_req, "rx_clk", int'(rx_clk), erx);
        chk(cur_req, "tx_clk", int'(tx_clk), etx);
        chk(cur_req, "in_search", int'(in_search), m_srch);
        chk(cur_req, "miss_one", int'(miss_one), m_one);
        chk(cur_req, "miss_two", int'(miss_two), m_two);
    endtask

    task automatic run_cells(int period, int n, int doff);
        for (int c = 0; c < n; c++) begin
            rxd = ~rxd;
            for (int k = 0; k < period; k++) begin
                if (doff != 0 && k == doff) rxd = ~rxd;
                step();
            end
        end
    endtask

    task automatic pulse_search();
        search_cmd = 1'b1; step(); search_cmd = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_miss_cmd = 1'b1; step(); clr_miss_cmd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL %s watchdog actual=timeout expected=finish", cur_req);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        repeat (4) step();
        rst = 1'b0;
        step();
        chk("R1", "reset in_search", int'(in_search), 1);
        chk("R1", "reset rx_clk", int'(rx_clk), 0);
        chk("R1", "reset miss_one", int'(miss_one), 0);

        // R12 disabled: edges do not leave search
        cur_req = "R12";
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 0) rxd = ~rxd;
            step();
        end
        chk("R12", "disabled in_search", int'(in_search), 1);

        // R2 search park with no input activity
        en = 1'b1;
        cur_req = "R2";
        repeat (20) step();
        chk("R2", "parked rx_clk", int'(rx_clk), 0);
        chk("R2", "parked tx_clk", int'(tx_clk), 0);

        // R3 search exit timing
        cur_req = "R3";
        rxd = ~rxd;
        step(); step();
        chk("R3", "rx_clk before exit", int'(rx_clk), 0);
        step();
        chk("R3", "rx_clk after exit", int'(rx_clk), 1);
        chk("R3", "in_search after exit", int'(in_search), 0);
        repeat (29) step();

        // R4 steady clock at the nominal rate
        cur_req = "R4";
        run_cells(32, 10, 0);
        // R5 mid-cell data transitions ignored
        cur_req = "R5";
        run_cells(32, 8, 16);
        run_cells(32, 4, 8);
        run_cells(32, 4, 24);
        // R6 slow input: late edges stretch
        cur_req = "R6";
        run_cells(33, 10, 16);
        // R7 fast input: early edges skip
        cur_req = "R7";
        run_cells(31, 10, 0);
        // R8 two edges inside one window
        cur_req = "R8";
        run_cells(32, 6, 2);
        run_cells(32, 4, 3);

        // R9 one missing clock transition
        cur_req = "R9";
        repeat (32) step();
        run_cells(32, 4, 0);
        chk("R9", "miss_one sticky", int'(miss_one), 1);
        chk("R9", "miss_two after single gap", int'(miss_two), 0);

        // R11 clear command
        cur_req = "R11";
        pulse_clr();
        chk("R11", "miss_one cleared", int'(miss_one), 0);

        // R10 silence leads to search
        cur_req = "R10";
        repeat (100) step();
        chk("R10", "in_search after silence", int'(in_search), 1);
        chk("R10", "miss_two set", int'(miss_two), 1);
        cur_req = "R11";
        pulse_clr();
        chk("R11", "miss_two cleared", int'(miss_two), 0);

        // R12 search command clears flags
        cur_req = "R12";
        rxd = ~rxd;
        repeat (32) step();
        run_cells(32, 4, 0);
        repeat (32) step();
        run_cells(32, 2, 0);
        chk("R12", "miss_one before command", int'(miss_one), 1);
        pulse_search();
        chk("R12", "in_search after command", int'(in_search), 1);
        chk("R12", "miss_one after command", int'(miss_one), 0);

        // sweep of periods, start phases and data patterns
        for (int p = 30; p <= 34; p++) begin
            for (int off = 0; off < 8; off++) begin
                for (int dm = 0; dm < 2; dm++) begin
                    cur_req = (p < 32) ? "R7" : ((p > 32) ? "R6" : "R4");
                    pulse_search();
                    repeat (off) step();
                    run_cells(p, 6, (dm != 0) ? p / 2 : 0);
                    if (off == 3) begin
                        cur_req = "R11";
                        pulse_clr();
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule